// File: doc/BRIEF.md
# Paged Monochrome Framebuffer Scan-Out

This block streams a small monochrome picture out of a display memory in which each byte holds a vertical strip of eight pixel rows (one "page") for a single column. A visible window of 96 columns by 16 rows is cut from that memory, starting 36 columns into each 132-byte page and at a programmable start line that wraps around the 64 memory lines. Each source pixel is repeated by an integer magnification factor in both directions, so the default output raster is 384 by 64 pixels, delivered one pixel per clock with valid, end-of-line and end-of-frame markers.

A frame is produced only when a redraw is pending. A pulse on the redraw input marks the picture as changed; a later frame-start request then launches one frame, and the pending flag drops when the last pixel leaves. Requests made while nothing is pending, or while a frame is running, are dropped. The start line and the two colour flags (invert, force all lit) are taken when a frame is launched and hold for the whole frame.

Top module: `scan_out_gen`

## Requirements
- R1: After reset, busy, redrawPending, memRd, pixValid, lineEnd and frameEnd are all low.
- R2: A redrawSet pulse makes redrawPending high from the next cycle; a frameStart while redrawPending is low launches nothing (busy and pixValid stay low).
- R3: A frameStart accepted at a clock edge makes busy high from that edge for exactly COLS*MAG*ROWS*MAG cycles, with one memory read per busy cycle and pixValid high on each following cycle, one pixel per cycle with no gaps.
- R4: Output source row y reads memory line L = (y + startLine) mod 64; source column x reads the byte at address (L / 8) * 132 + 36 + x, and the pixel is bit (L mod 8) of that byte, bit 0 being the top row of a page.
- R5: Each source pixel appears on MAG consecutive output pixels of a row, and each source row on MAG consecutive output rows.
- R6: With invert set and all-on clear, each pixel is the complement of its memory bit; with both clear it equals the memory bit.
- R7: With all-on set, every pixel is 1 whatever the memory holds and whatever invert is.
- R8: lineEnd is high with the last pixel of every output row and only then; frameEnd is high with the last pixel of the frame and only then.
- R9: redrawPending goes low in the cycle in which frameEnd is shown, so a following frameStart with no new redrawSet is dropped.
- R10: startLine, invertEn and allOnEn are captured when a frame is accepted; changing them during the frame has no effect on that frame's pixels.
- R11: A frameStart while busy is high is dropped and does not restart or lengthen the running frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| redrawSet | input | 1 | Pulse marking the picture as changed |
| frameStart | input | 1 | Request to produce one frame |
| startLine | input | 6 | Memory line shown on the top output row |
| invertEn | input | 1 | Complement the memory bits |
| allOnEn | input | 1 | Force every pixel lit |
| memAddr | output | 11 | Display memory byte address |
| memRd | output | 1 | Display memory read strobe |
| memData | input | 8 | Byte returned one cycle after memRd |
| pixOut | output | 1 | Pixel value |
| pixValid | output | 1 | pixOut carries a pixel |
| lineEnd | output | 1 | Last pixel of an output row |
| frameEnd | output | 1 | Last pixel of the frame |
| busy | output | 1 | A frame is being fetched |
| redrawPending | output | 1 | A redraw has been requested and not yet drawn |

## Verification
The checks assume that the memory answers a read with its byte exactly one clock after memRd is high, and that memory contents do not change while a frame is being fetched; the bench memory is a registered-read array and it is only rewritten while busy is low. The control inputs are treated as arbitrary at any cycle: the bench changes the start line and both colour flags in the middle of a frame and issues extra frame requests while busy, while its reference model keeps the values captured at frame launch. Start lines near the top of the 64-line range are used so that the line wrap is exercised.

// File: rtl/scan_pkg.sv
package scan_pkg;
  // Strobes from the scan control to the datapath
  typedef struct packed {
    logic load;     // frame accepted: capture start line and colour flags
    logic issue;    // fetch one byte this cycle
    logic lastCol;  // this fetch is the last pixel of an output row
    logic lastRow;  // this fetch belongs to the last output row
  } scanStrobe_t;
endpackage

// File: rtl/scan_ctrl.sv
module scan_ctrl
  import scan_pkg::*;
#(
  parameter int COLS = 96,
  parameter int ROWS = 16,
  parameter int MAG  = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      redrawSet,
  input  logic                      frameStart,
  output scanStrobe_t               stb,
  output logic [$clog2(COLS)-1:0]   colIdx,
  output logic [$clog2(ROWS)-1:0]   rowIdx,
  output logic                      busy,
  output logic                      redrawPending
);
  localparam int CW = $clog2(COLS);
  localparam int RW = $clog2(ROWS);

  logic          runQ;
  logic          redrawQ;
  logic [CW-1:0] colQ;
  logic [RW-1:0] rowQ;
  logic          magXLast;
  logic          magYLast;
  logic          colAtEnd;
  logic          rowAtEnd;
  logic          lineLast;
  logic          frameLast;
  logic          accept;

  assign colAtEnd  = (colQ == CW'(COLS - 1));
  assign rowAtEnd  = (rowQ == RW'(ROWS - 1));
  assign lineLast  = colAtEnd && magXLast;
  assign frameLast = lineLast && rowAtEnd && magYLast;
  assign accept    = frameStart && !runQ && redrawQ;

  // Replication counters exist only when magnification is above one
  generate
    if (MAG > 1) begin : g_rep
      localparam int MW = $clog2(MAG);
      logic [MW-1:0] magXQ;
      logic [MW-1:0] magYQ;
      assign magXLast = (magXQ == MW'(MAG - 1));
      assign magYLast = (magYQ == MW'(MAG - 1));
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          magXQ <= '0;
          magYQ <= '0;
        end else if (accept) begin
          magXQ <= '0;
          magYQ <= '0;
        end else if (runQ) begin
          magXQ <= magXLast ? '0 : magXQ + 1'b1;
          if (lineLast) magYQ <= magYLast ? '0 : magYQ + 1'b1;
        end
      end
    end else begin : g_norep
      assign magXLast = 1'b1;
      assign magYLast = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ <= 1'b0;
      colQ <= '0;
      rowQ <= '0;
    end else if (accept) begin
      runQ <= 1'b1;
      colQ <= '0;
      rowQ <= '0;
    end else if (runQ) begin
      if (magXLast) colQ <= colAtEnd ? '0 : colQ + 1'b1;
      if (lineLast && magYLast) rowQ <= rowAtEnd ? '0 : rowQ + 1'b1;
      if (frameLast) runQ <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      redrawQ <= 1'b0;
    else if (redrawSet)             redrawQ <= 1'b1;
    else if (runQ && frameLast)     redrawQ <= 1'b0;
  end

  assign stb.load    = accept;
  assign stb.issue   = runQ;
  assign stb.lastCol = lineLast;
  assign stb.lastRow = rowAtEnd && magYLast;
  assign colIdx        = colQ;
  assign rowIdx        = rowQ;
  assign busy          = runQ;
  assign redrawPending = redrawQ;

  // R2
  start_needs_redraw_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(runQ) |-> $past(redrawQ));
  // R3
  frame_origin_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(runQ) |-> (colQ == '0 && rowQ == '0));
  // R11
  no_early_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (runQ && !frameLast) |=> runQ);
  // R9
  redraw_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (runQ && frameLast && !redrawSet) |=> !redrawQ);
endmodule

// File: rtl/scan_dp.sv
module scan_dp
  import scan_pkg::*;
#(
  parameter int COLS      = 96,
  parameter int ROWS      = 16,
  parameter int STRIDE    = 132,
  parameter int WIN_OFF   = 36,
  parameter int PAGE_ROWS = 8,
  parameter int PAGES     = 8
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  scanStrobe_t                            stb,
  input  logic [$clog2(COLS)-1:0]                colIdx,
  input  logic [$clog2(ROWS)-1:0]                rowIdx,
  input  logic [$clog2(PAGE_ROWS*PAGES)-1:0]     startLine,
  input  logic                                   invertEn,
  input  logic                                   allOnEn,
  output logic [$clog2(STRIDE*PAGES)-1:0]        memAddr,
  output logic                                   memRd,
  input  logic [PAGE_ROWS-1:0]                   memData,
  output logic                                   pixOut,
  output logic                                   pixValid,
  output logic                                   lineEnd,
  output logic                                   frameEnd
);
  localparam int LINES = PAGE_ROWS * PAGES;
  localparam int LW    = $clog2(LINES);
  localparam int BW    = $clog2(PAGE_ROWS);
  localparam int PW    = LW - BW;
  localparam int AW    = $clog2(STRIDE * PAGES);

  logic [LW-1:0] startQ;
  logic          invQ;
  logic          allOnQ;
  logic [LW-1:0] lineNum;
  logic [PW-1:0] pageNum;
  logic [BW-1:0] bitNum;
  logic          vldQ;
  logic [BW-1:0] bitQ;
  logic          eolQ;
  logic          eofQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startQ <= '0;
      invQ   <= 1'b0;
      allOnQ <= 1'b0;
    end else if (stb.load) begin
      startQ <= startLine;
      invQ   <= invertEn;
      allOnQ <= allOnEn;
    end
  end

  // Line rotation wraps naturally in LW bits
  assign lineNum = LW'(rowIdx) + startQ;
  assign pageNum = lineNum[LW-1:BW];
  assign bitNum  = lineNum[BW-1:0];
  assign memAddr = AW'(int'(pageNum) * STRIDE + WIN_OFF + int'(colIdx));
  assign memRd   = stb.issue;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vldQ <= 1'b0;
      bitQ <= '0;
      eolQ <= 1'b0;
      eofQ <= 1'b0;
    end else begin
      vldQ <= stb.issue;
      bitQ <= bitNum;
      eolQ <= stb.issue && stb.lastCol;
      eofQ <= stb.issue && stb.lastCol && stb.lastRow;
    end
  end

  assign pixOut   = vldQ && (allOnQ || (memData[bitQ] ^ invQ));
  assign pixValid = vldQ;
  assign lineEnd  = eolQ;
  assign frameEnd = eofQ;

  // R4
  addr_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    memRd |-> (int'(memAddr) >= WIN_OFF && int'(memAddr) < STRIDE * PAGES));
  // R3
  valid_follows_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    pixValid |-> $past(memRd));
  // R8
  eof_on_eol_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameEnd |-> (lineEnd && pixValid));
  // R10
  flags_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memRd && !stb.load) |=> ($stable(startQ) && $stable(invQ) && $stable(allOnQ)));
endmodule

// File: rtl/scan_out_gen.sv
module scan_out_gen
  import scan_pkg::*;
#(
  parameter int COLS      = 96,
  parameter int ROWS      = 16,
  parameter int MAG       = 4,
  parameter int STRIDE    = 132,
  parameter int WIN_OFF   = 36,
  parameter int PAGE_ROWS = 8,
  parameter int PAGES     = 8
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic                                redrawSet,
  input  logic                                frameStart,
  input  logic [$clog2(PAGE_ROWS*PAGES)-1:0]  startLine,
  input  logic                                invertEn,
  input  logic                                allOnEn,
  output logic [$clog2(STRIDE*PAGES)-1:0]     memAddr,
  output logic                                memRd,
  input  logic [PAGE_ROWS-1:0]                memData,
  output logic                                pixOut,
  output logic                                pixValid,
  output logic                                lineEnd,
  output logic                                frameEnd,
  output logic                                busy,
  output logic                                redrawPending
);
  scanStrobe_t               stb;
  logic [$clog2(COLS)-1:0]   colIdx;
  logic [$clog2(ROWS)-1:0]   rowIdx;

  scan_ctrl #(.COLS(COLS), .ROWS(ROWS), .MAG(MAG)) u_ctrl (
    .clk(clk), .rstN(rstN), .redrawSet(redrawSet), .frameStart(frameStart),
    .stb(stb), .colIdx(colIdx), .rowIdx(rowIdx),
    .busy(busy), .redrawPending(redrawPending)
  );

  scan_dp #(.COLS(COLS), .ROWS(ROWS), .STRIDE(STRIDE), .WIN_OFF(WIN_OFF),
            .PAGE_ROWS(PAGE_ROWS), .PAGES(PAGES)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .colIdx(colIdx), .rowIdx(rowIdx),
    .startLine(startLine), .invertEn(invertEn), .allOnEn(allOnEn),
    .memAddr(memAddr), .memRd(memRd), .memData(memData),
    .pixOut(pixOut), .pixValid(pixValid), .lineEnd(lineEnd), .frameEnd(frameEnd)
  );
endmodule

// File: tb/tb_scan_out_gen.sv
module tb_scan_out_gen;
  localparam int COLS = 96, ROWS = 16, MAG = 4, STRIDE = 132, WIN_OFF = 36;
  localparam int OUTW = COLS * MAG, OUTH = ROWS * MAG, NPIX = OUTW * OUTH;
  localparam int MEMSZ = STRIDE * 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic redrawSet = 1'b0, frameStart = 1'b0, invertEn = 1'b0, allOnEn = 1'b0;
  logic [5:0] startLine = '0;
  logic [10:0] memAddr;
  logic memRd;
  logic [7:0] memData;
  logic pixOut, pixValid, lineEnd, frameEnd, busy, redrawPending;

  always #10 clk = ~clk;

  scan_out_gen dut (
    .clk(clk), .rstN(rstN), .redrawSet(redrawSet), .frameStart(frameStart),
    .startLine(startLine), .invertEn(invertEn), .allOnEn(allOnEn),
    .memAddr(memAddr), .memRd(memRd), .memData(memData),
    .pixOut(pixOut), .pixValid(pixValid), .lineEnd(lineEnd), .frameEnd(frameEnd),
    .busy(busy), .redrawPending(redrawPending)
  );

  logic [7:0] mem [0:MEMSZ-1];
  initial memData = 8'h00;
  always @(posedge clk) if (memRd) memData <= mem[memAddr];

  int checks = 0, errors = 0;
  string phaseTag = "";

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Reference model
  int cyc = 0, runStart = -100, runEnd = -100;
  bit mPend = 0;
  bit qPix[$], qEol[$], qEof[$];
  string qTag[$];

  always @(posedge clk) begin
    bit acc, clr, prevBusy, b;
    int ln, a, sy;
    if (!rstN) begin
      cyc = 0; runStart = -100; runEnd = -100; mPend = 0;
      qPix.delete(); qEol.delete(); qEof.delete(); qTag.delete();
    end else begin
      cyc++;
      prevBusy = (cyc - 1 >= runStart) && (cyc - 1 <= runEnd);
      acc = frameStart && !prevBusy && mPend;
      clr = (cyc == runEnd + 1);
      if (acc) begin
        runStart = cyc;
        runEnd = cyc + NPIX - 1;
        for (int oy = 0; oy < OUTH; oy++) begin
          sy = oy / MAG;
          ln = (sy + int'(startLine)) % 64;
          for (int ox = 0; ox < OUTW; ox++) begin
            a = (ln / 8) * STRIDE + WIN_OFF + ox / MAG;
            b = mem[a][ln % 8];
            qPix.push_back(allOnEn ? 1'b1 : (b ^ invertEn));
            qEol.push_back(ox == OUTW - 1);
            qEof.push_back(ox == OUTW - 1 && oy == OUTH - 1);
            qTag.push_back({phaseTag, allOnEn ? " R7" : (invertEn ? " R6 R5" : " R4 R5")});
          end
        end
      end
      if (clr) mPend = 0;
      if (redrawSet) mPend = 1;
    end
  end

  always @(negedge clk) begin
    bit eb, ev, ep, ee, ef;
    string t;
    if (rstN) begin
      eb = (cyc >= runStart) && (cyc <= runEnd);
      ev = (cyc >= runStart + 1) && (cyc <= runEnd + 1);
      chk(busy == eb, {phaseTag, " R11 R3"}, "busy", busy, eb);
      chk(memRd == eb, {phaseTag, " R3"}, "memRd", memRd, eb);
      chk(redrawPending == mPend, {phaseTag, " R2 R9"}, "redrawPending", redrawPending, mPend);
      chk(pixValid == ev, {phaseTag, " R3"}, "pixValid", pixValid, ev);
      if (ev && qPix.size() > 0) begin
        ep = qPix.pop_front(); ee = qEol.pop_front(); ef = qEof.pop_front(); t = qTag.pop_front();
        chk(pixOut == ep, t, "pixOut", pixOut, ep);
        chk(lineEnd == ee, {phaseTag, " R8"}, "lineEnd", lineEnd, ee);
        chk(frameEnd == ef, {phaseTag, " R8"}, "frameEnd", frameEnd, ef);
      end else begin
        chk(!lineEnd && !frameEnd, {phaseTag, " R8"}, "markers idle", lineEnd | frameEnd, 0);
      end
    end
  end

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic pulse(ref logic sig);
    sig = 1'b1;
    @(negedge clk);
    sig = 1'b0;
  endtask

  task automatic waitIdle();
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < MEMSZ; i++) mem[i] = 8'((i * 37 + 11) ^ (i >> 3));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy, "R1", "busy in reset", busy, 0);
    chk(!redrawPending, "R1", "redrawPending in reset", redrawPending, 0);
    chk(!memRd, "R1", "memRd in reset", memRd, 0);
    chk(!pixValid && !lineEnd && !frameEnd, "R1", "outputs in reset", pixValid, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2: request with nothing pending is dropped
    phaseTag = "R2";
    pulse(frameStart);
    repeat (6) @(negedge clk);
    chk(!busy, "R2", "busy after dropped request", busy, 0);

    // Plain frame, start line 0
    phaseTag = "R4";
    pulse(redrawSet);
    startLine = 6'd0;
    pulse(frameStart);
    waitIdle();

    // R9: pending cleared, next request dropped
    phaseTag = "R9";
    pulse(frameStart);
    repeat (6) @(negedge clk);
    chk(!busy && !redrawPending, "R9", "no frame without new redraw", busy, 0);

    // Wrapping start line with invert
    phaseTag = "R6";
    mem[WIN_OFF] = 8'hA5;
    mem[7 * STRIDE + WIN_OFF + COLS - 1] = 8'h3C;
    pulse(redrawSet);
    startLine = 6'd60;
    invertEn = 1'b1;
    pulse(frameStart);
    waitIdle();

    // All-on, then change controls and request again mid-frame
    phaseTag = "R10 R11";
    for (int i = 0; i < 40; i++) mem[i * 25] = 8'h00;
    pulse(redrawSet);
    startLine = 6'd13;
    allOnEn = 1'b1;
    invertEn = 1'b1;
    pulse(frameStart);
    repeat (100) @(negedge clk);
    startLine = 6'd5;
    allOnEn = 1'b0;
    invertEn = 1'b0;
    pulse(frameStart);
    waitIdle();

    // Frame after the mid-frame changes uses the new values
    phaseTag = "R10";
    pulse(redrawSet);
    pulse(frameStart);
    waitIdle();
    chk(qPix.size() == 0, "R3", "pixels left over", qPix.size(), 0);
    finishRun();
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R3 watchdog expired actual=%0d expected=%0d", 1, 0);
    finishRun();
  end
endmodule